// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is the logic core of a small programmable logic element. Eighteen input signals, which may be pins or feedback from downstream macrocells, each drive two array columns: the signal itself and its inverse. Each row of the array is one product term, the AND of whichever columns its configuration bits leave connected. Rows are collected into ten output groups. Each group owns an enable row plus a run of logic rows, and the logic rows are ORed into the group's sum term. Two further rows, shared by all groups, give a global asynchronous-clear request and a global synchronous-set request.

The configuration lives in a flat bit vector that is written one bit at a time through a plain address/data/strobe port, normally before operation starts. A stored 1 keeps a column connected to its row. A stored 0 removes the column. Reset returns every bit to 1. Because a fully connected row ANDs each signal with its own inverse, every term is false after reset. The array itself is combinational: the sum terms, enables, clear and set follow the inputs directly. Alongside them, the block presents twenty macrocell mode bits, two per group, to the macrocells.

Top module: `pla_sop_array`

## Requirements
- R1: While reset is held, and after its release with no writes, `sum_o`, `oe_o`, `arst_o` and `spre_o` are all 0 for any `in_sig`, and `mode_o` is all ones.
- R2: Column 2*i carries `in_sig[i]` and column 2*i+1 carries its inverse. A stored 1 connects the column to the row, so the row is true only when every connected column is 1.
- R3: A row whose 36 bits are all 0 evaluates to constant true.
- R4: Configuration address = row*36 + column. Row 0 is the clear row and row 95 is the set row. Group g starts at row 1 + sum over k<g of (1 + terms(k)). Its first row is the enable row and the logic rows follow it. Groups 4 and 5 have 10 logic rows and all other groups have 8, which puts group 4 at rows 37..47, group 5 at rows 48..58 and group 9 at rows 86..94.
- R5: `sum_o[g]` is the OR of all logic rows of group g, including the ninth and tenth rows of groups 4 and 5.
- R6: `oe_o[g]` equals the enable row of group g.
- R7: `arst_o` equals row 0 and `spre_o` equals row 95.
- R8: Address 3456 + 2*g + k (k = 0 or 1) holds `mode_o[2*g + k]`.
- R9: Writes to addresses 3476 and above (the 64-bit identification area and beyond) change no output.
- R10: A write takes effect at the clock edge where `cfg_we` is 1, so the outputs reflect it in the following cycle. With `cfg_we` at 0, the address and data inputs have no effect.
- R11: Asserting reset after programming restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset; sets all configuration bits to 1 |
| cfg_we | input | 1 | Write strobe for one configuration bit |
| cfg_addr | input | 12 | Configuration bit address |
| cfg_data | input | 1 | Value to store |
| in_sig | input | 18 | Array input signals |
| sum_o | output | 10 | Sum term per output group |
| oe_o | output | 10 | Enable term per output group |
| arst_o | output | 1 | Global asynchronous-clear term |
| spre_o | output | 1 | Global synchronous-set term |
| mode_o | output | 20 | Macrocell mode bits, two per group |

## Verification
Two situations are hard to reach from the ports. The first is a product term that is constant true, which needs all 36 of its bits cleared. The second is the ninth and tenth logic rows of the wide groups, which sit at addresses only the uneven row layout reaches. The bench uses a row-programming task that clears every column except a chosen keep mask. With it, the bench empties one row of group 5 completely and wires the last row of group 4 to a single input, then drives input vectors that separate each programmed row's contribution from the others. Writes to the identification area and strobe-low cycles are followed by full vector checks, so any stray change would show at the outputs.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // number of logic rows in group g
  function automatic int grp_terms(input int g, input int narrow_t, input int wide_t,
                                   input int wide_a, input int wide_b);
    return (g == wide_a || g == wide_b) ? wide_t : narrow_t;
  endfunction

  // first row (the enable row) of group g; row 0 is the shared clear row
  function automatic int grp_base(input int g, input int narrow_t, input int wide_t,
                                  input int wide_a, input int wide_b);
    int acc;
    acc = 1;
    for (int k = 0; k < g; k++)
      acc += 1 + grp_terms(k, narrow_t, wide_t, wide_a, wide_b);
    return acc;
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int STORE_BITS = 3476,
  parameter int ADDR_W     = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic                  wr_data,
  output logic [STORE_BITS-1:0] bits_o
);

  logic [STORE_BITS-1:0] store_q;
  logic                  in_range;

  assign in_range = (wr_addr < ADDR_W'(STORE_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      store_q <= '1;
    else if (wr_en && in_range)
      store_q[wr_addr] <= wr_data;
  end

  assign bits_o = store_q;

endmodule

// File: rtl/pla_pterm.sv
module pla_pterm #(
  parameter int COLS = 36
) (
  input  logic [COLS-1:0] col_i,
  input  logic [COLS-1:0] link_i,
  output logic            term_o
);

  // a linked column must be 1; an unlinked column is don't-care
  assign term_o = &(col_i | ~link_i);

endmodule

// File: rtl/pla_or_group.sv
module pla_or_group #(
  parameter int N_TERMS = 8
) (
  input  logic [N_TERMS-1:0] term_i,
  output logic               sum_o
);

  assign sum_o = |term_i;

endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array
  import pla_pkg::*;
#(
  parameter int N_IN     = 18,
  parameter int N_GRP    = 10,
  parameter int NARROW_T = 8,
  parameter int WIDE_T   = 10,
  parameter int WIDE_A   = 4,
  parameter int WIDE_B   = 5,
  parameter int SIG_BITS = 64,
  localparam int COLS       = 2 * N_IN,
  localparam int N_ROWS     = grp_base(N_GRP, NARROW_T, WIDE_T, WIDE_A, WIDE_B) + 1,
  localparam int ARRAY_BITS = N_ROWS * COLS,
  localparam int MODE_BITS  = 2 * N_GRP,
  localparam int STORE_BITS = ARRAY_BITS + MODE_BITS,
  localparam int ADDR_W     = $clog2(STORE_BITS + SIG_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic                 cfg_data,
  input  logic [N_IN-1:0]      in_sig,
  output logic [N_GRP-1:0]     sum_o,
  output logic [N_GRP-1:0]     oe_o,
  output logic                 arst_o,
  output logic                 spre_o,
  output logic [MODE_BITS-1:0] mode_o
);

  logic [STORE_BITS-1:0] cfg_bits;
  logic [COLS-1:0]       col_vec;
  logic [N_ROWS-1:0]     row_term;

  pla_cfg_store #(
    .STORE_BITS(STORE_BITS),
    .ADDR_W    (ADDR_W)
  ) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_we),
    .wr_addr(cfg_addr),
    .wr_data(cfg_data),
    .bits_o (cfg_bits)
  );

  // column pairs: true then inverse of each input
  for (genvar i = 0; i < N_IN; i++) begin : g_col
    assign col_vec[2*i]   = in_sig[i];
    assign col_vec[2*i+1] = ~in_sig[i];
  end

  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    pla_pterm #(.COLS(COLS)) u_pt (
      .col_i (col_vec),
      .link_i(cfg_bits[r*COLS +: COLS]),
      .term_o(row_term[r])
    );
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    localparam int BASE = grp_base(g, NARROW_T, WIDE_T, WIDE_A, WIDE_B);
    localparam int NT   = grp_terms(g, NARROW_T, WIDE_T, WIDE_A, WIDE_B);

    assign oe_o[g] = row_term[BASE];

    pla_or_group #(.N_TERMS(NT)) u_or (
      .term_i(row_term[BASE+1 +: NT]),
      .sum_o (sum_o[g])
    );
  end

  assign arst_o = row_term[0];
  assign spre_o = row_term[N_ROWS-1];
  assign mode_o = cfg_bits[ARRAY_BITS +: MODE_BITS];

endmodule

// File: rtl/pla_sop_array_chk.sv
module pla_sop_array_chk #(
  parameter int ADDR_W     = 12,
  parameter int STORE_BITS = 3476,
  parameter int MODE_BASE  = 3456,
  parameter int MODE_BITS  = 20,
  parameter int N_GRP      = 10,
  localparam int MIDX_W    = $clog2(MODE_BITS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_we,
  input logic [ADDR_W-1:0]    cfg_addr,
  input logic                 cfg_data,
  input logic [N_GRP-1:0]     sum_o,
  input logic [N_GRP-1:0]     oe_o,
  input logic                 arst_o,
  input logic                 spre_o,
  input logic [MODE_BITS-1:0] mode_o
);

  logic [ADDR_W-1:0] mode_off;
  logic              mode_hit;
  logic              last_hit;
  logic [MIDX_W-1:0] last_idx;
  logic              last_data;

  assign mode_off = cfg_addr - ADDR_W'(MODE_BASE);
  assign mode_hit = cfg_we && (cfg_addr >= ADDR_W'(MODE_BASE)) &&
                    (cfg_addr < ADDR_W'(STORE_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_hit  <= 1'b0;
      last_idx  <= '0;
      last_data <= 1'b0;
    end else begin
      last_hit  <= mode_hit;
      last_idx  <= mode_off[MIDX_W-1:0];
      last_data <= cfg_data;
    end
  end

  // R1 / R11: reset leaves every term false and mode bits at one
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (sum_o == '0 && oe_o == '0 && !arst_o && !spre_o && mode_o == '1));

  // R8: a write into the mode area lands on the matching mode bit
  p_mode_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_hit |-> (mode_o[last_idx] == last_data));

  // R9: writes at or above the identification area change no mode bit
  p_sig_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr >= ADDR_W'(STORE_BITS)) |=> $stable(mode_o));

  // R10: with the strobe low the configuration holds
  p_hold_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(mode_o));

endmodule

bind pla_sop_array pla_sop_array_chk #(
  .ADDR_W    (ADDR_W),
  .STORE_BITS(STORE_BITS),
  .MODE_BASE (ARRAY_BITS),
  .MODE_BITS (MODE_BITS),
  .N_GRP     (N_GRP)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cfg_we  (cfg_we),
  .cfg_addr(cfg_addr),
  .cfg_data(cfg_data),
  .sum_o   (sum_o),
  .oe_o    (oe_o),
  .arst_o  (arst_o),
  .spre_o  (spre_o),
  .mode_o  (mode_o)
);

// File: tb/pla_sop_array_test.sv
module pla_sop_array_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [11:0] cfg_addr = '0;
  logic        cfg_data = 1'b0;
  logic [17:0] in_sig = '0;
  logic [9:0]  sum_o, oe_o;
  logic        arst_o, spre_o;
  logic [19:0] mode_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  pla_sop_array uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .in_sig(in_sig), .sum_o(sum_o), .oe_o(oe_o),
    .arst_o(arst_o), .spre_o(spre_o), .mode_o(mode_o)
  );

  typedef struct packed {
    logic [17:0] vin;
    logic [9:0]  sum;
    logic [9:0]  oe;
    logic        ar;
    logic        sp;
  } vec_t;

  // Program: sum0 = in0 | (~in1 & in2); sum4 = in17 (tenth row);
  // sum5 = 1 (empty row); oe9 = ~in3; arst = in5 & in6; spre = ~in7
  localparam vec_t VECS [10] = '{
    '{18'h00000, 10'h020, 10'h200, 1'b0, 1'b1},  // R3 constant row
    '{18'h00001, 10'h021, 10'h200, 1'b0, 1'b1},  // R2 true column
    '{18'h00004, 10'h021, 10'h200, 1'b0, 1'b1},  // R5 second row
    '{18'h00006, 10'h020, 10'h200, 1'b0, 1'b1},  // R2 inverse column
    '{18'h20000, 10'h030, 10'h200, 1'b0, 1'b1},  // R4 R5 tenth row
    '{18'h00008, 10'h020, 10'h000, 1'b0, 1'b1},  // R6 enable row
    '{18'h00060, 10'h020, 10'h200, 1'b1, 1'b1},  // R7 clear row
    '{18'h00080, 10'h020, 10'h200, 1'b0, 1'b0},  // R7 set row
    '{18'h3FFFF, 10'h031, 10'h000, 1'b1, 1'b0},  // all high
    '{18'h00020, 10'h020, 10'h200, 1'b0, 1'b1}   // R7 partial clear
  };

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input bit d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a[11:0]; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // clear every column of a row except those in keep
  task automatic prog_row(input int row, input logic [35:0] keep);
    for (int c = 0; c < 36; c++)
      if (!keep[c]) wr(row * 36 + c, 1'b0);
  endtask

  task automatic run_vec(input int i, input string tag);
    in_sig = VECS[i].vin;
    #1;
    chk($sformatf("%s vector %0d", tag, i), {sum_o, oe_o, arst_o, spre_o},
        {VECS[i].sum, VECS[i].oe, VECS[i].ar, VECS[i].sp});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: in reset, all terms false for mixed inputs
    in_sig = 18'h2A5C3; #1;
    chk("R1 in reset", {sum_o, oe_o, arst_o, spre_o, mode_o}, {22'h0, 20'hFFFFF});
    rst_n = 1'b1;
    @(negedge clk);
    in_sig = 18'h3FFFF; #1;
    chk("R1 after release", {sum_o, oe_o, arst_o, spre_o, mode_o}, {22'h0, 20'hFFFFF});

    // R4 layout: group0 logic rows 2,3; group4 last row 47; group5 row 57;
    // group9 enable row 86; clear row 0; set row 95
    prog_row(2,  36'h1 << 0);
    prog_row(3,  (36'h1 << 3) | (36'h1 << 4));
    prog_row(47, 36'h1 << 34);
    prog_row(57, 36'h0);
    prog_row(86, 36'h1 << 7);
    prog_row(0,  (36'h1 << 10) | (36'h1 << 12));
    prog_row(95, 36'h1 << 15);

    for (int i = 0; i < 10; i++) run_vec(i, "R2 R3 R4 R5 R6 R7");

    // R8: mode bits for group 3 S1 (3463) and group 0 S0 (3456)
    wr(3463, 1'b0); #1;
    chk("R8 group3 bit1", mode_o, 20'hFFF7F);
    wr(3456, 1'b0); #1;
    chk("R8 group0 bit0", mode_o, 20'hFFF7E);

    // R10: strobe low, address and data present
    @(negedge clk);
    cfg_addr = 12'd3475; cfg_data = 1'b0;
    @(negedge clk);
    cfg_addr = 12'd2;    cfg_data = 1'b1;
    @(negedge clk); #1;
    chk("R10 mode held", mode_o, 20'hFFF7E);
    run_vec(2, "R10 row held");

    // R9: identification area and beyond
    wr(3476, 1'b0);
    wr(3539, 1'b0);
    wr(4095, 1'b0); #1;
    chk("R9 mode unchanged", mode_o, 20'hFFF7E);
    run_vec(0, "R9");
    run_vec(8, "R9");

    // R11: reset after programming
    @(negedge clk);
    rst_n = 1'b0; in_sig = 18'h00000; #1;
    chk("R11 in reset", {sum_o, oe_o, arst_o, spre_o, mode_o}, {22'h0, 20'hFFFFF});
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    in_sig = 18'h00060; #1;
    chk("R11 after release", {sum_o, oe_o, arst_o, spre_o, mode_o}, {22'h0, 20'hFFFFF});

    finish_run();
  end

endmodule